// File: doc/BRIEF.md
# Domain Power-Up Sequencer

This block governs eight switchable subsystem domains (six compute groups plus a narrow and a wide chip-to-chip link). Each domain has three outputs: bus isolation, clock enable and an active-high domain reset. Software controls the block through a small write/read register port. It can set the three controls of a domain directly, or it can write a command bit that starts a wake or sleep sequence enforced in hardware for that domain. Each domain reports whether a sequence is running and whether it is awake.

A wake sequence pulses the domain reset, then opens the clock, and only then removes isolation. A sleep sequence runs the other way: it isolates first and gates the clock afterwards. The domain reset is not touched during sleep. The global reset never places a domain in reset. It leaves every domain isolated and clock-gated with its reset released, so that no large inrush occurs. The global reset is asserted asynchronously and released through a synchroniser.

Top module: `domain_seq_ctrl`

## Requirements
- R1: After global reset every domain is isolated (isolate = 1), clock-gated (clock enable = 0), has its domain reset released (0), and is not busy.
- R2: A write to byte offset 0x00, 0x04 or 0x08 sets, for every non-busy domain i, isolate, clock enable or domain reset respectively to wdata bit i. A read of the same offset returns those bits in [7:0].
- R3: A direct control write leaves the controls of any busy domain unchanged.
- R4: Writing 1 to bit i at offset 0x0C starts a wake of domain i in the cycle the write is sampled. The block then forces isolate = 1 and clock enable = 0, holds the domain reset high for 4 cycles, enables the clock 2 cycles after the reset release, and removes isolation 2 cycles after that. Busy is high from the command until isolation drops.
- R5: During a wake, the clock enable rises only while the domain reset is low, and isolation falls only while the clock is enabled and the reset is low.
- R6: A wake command to an awake domain, or any command to a busy domain, is ignored.
- R7: Writing 1 to bit i at offset 0x10 isolates domain i at once and gates its clock 2 cycles later. Busy covers those cycles, and the domain reset is left unchanged.
- R8: A domain is awake when its clock is enabled, it is not isolated and its reset is low. Offset 0x14 reads busy in [7:0] and awake in [15:8], and a domain is never busy and awake at once.
- R9: Read data appears on rdata one cycle after the address. Offsets 0x0C, 0x10, unmapped offsets and addresses with either low two bits set read as 0, and writes to those addresses change no control.
- R10: One command write may start sequences for several domains, and they advance in parallel.
- R11: Writes sampled on the first two clock edges after the global reset is released are ignored. The write on the third edge takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Global reset, active high, asynchronous assertion |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 5 | Byte address for reads and writes |
| wdata | input | 8 | Write data, one bit per domain |
| rdata | output | 32 | Registered read data |
| iso_o | output | 8 | Per-domain bus isolation |
| clk_en_o | output | 8 | Per-domain clock enable |
| dom_rst_o | output | 8 | Per-domain reset, active high |
| busy_o | output | 8 | Per-domain sequence in progress |
| awake_o | output | 8 | Per-domain awake status |

## Verification
Assertions check the ordering rules on every cycle: the clock opens only with the reset released, de-isolation happens only on a clocked domain out of reset, sleep gates the clock only behind isolation, no sequence raises a released reset, and busy and awake never coincide. The exact cycle counts of the reset pulse and the step waits, the ignored commands and writes, the read decode and the synchronised reset release are shown only by the bench's scenarios. The bench compares against a behavioural reference model on every clock.

// File: rtl/domseq_pkg.sv
package domseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_CLK,
    ST_ISO,
    ST_GATE
  } dom_state_e;

  // word indices within the register window (byte offset / 4)
  localparam int unsigned REG_ISO   = 0;
  localparam int unsigned REG_CEN   = 1;
  localparam int unsigned REG_RST   = 2;
  localparam int unsigned REG_WAKE  = 3;
  localparam int unsigned REG_SLEEP = 4;
  localparam int unsigned REG_STAT  = 5;
endpackage

// File: rtl/domseq_rst_sync.sv
module domseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async,
  output logic rst_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async) chain <= '1;
    else           chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_sync = chain[STAGES-1];
endmodule

// File: rtl/domseq_unit.sv
module domseq_unit
  import domseq_pkg::*;
#(
  parameter int HOLD_CYC = 4,
  parameter int STEP_CYC = 2
) (
  input  logic clk,
  input  logic srst,
  input  logic wr_iso,
  input  logic wr_cen,
  input  logic wr_rst,
  input  logic d,
  input  logic wake_cmd,
  input  logic sleep_cmd,
  output logic iso,
  output logic cen,
  output logic drst,
  output logic busy,
  output logic awake
);
  localparam int MAXW  = (HOLD_CYC > STEP_CYC) ? HOLD_CYC : STEP_CYC;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(STEP_CYC - 1);

  dom_state_e       state;
  logic [CNT_W-1:0] cnt;

  assign busy  = (state != ST_IDLE);
  assign awake = cen & ~iso & ~drst;

  always_ff @(posedge clk) begin
    if (srst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      iso   <= 1'b1;
      cen   <= 1'b0;
      drst  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (wake_cmd && !awake) begin
            state <= ST_RST;
            drst  <= 1'b1;
            iso   <= 1'b1;
            cen   <= 1'b0;
          end else if (sleep_cmd) begin
            state <= ST_GATE;
            iso   <= 1'b1;
          end else begin
            if (wr_iso) iso  <= d;
            if (wr_cen) cen  <= d;
            if (wr_rst) drst <= d;
          end
        end
        ST_RST: begin
          if (cnt == HOLD_LAST) begin
            drst  <= 1'b0;
            cnt   <= '0;
            state <= ST_CLK;
          end else cnt <= cnt + 1'b1;
        end
        ST_CLK: begin
          if (cnt == STEP_LAST) begin
            cen   <= 1'b1;
            cnt   <= '0;
            state <= ST_ISO;
          end else cnt <= cnt + 1'b1;
        end
        ST_ISO: begin
          if (cnt == STEP_LAST) begin
            iso   <= 1'b0;
            cnt   <= '0;
            state <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        ST_GATE: begin
          if (cnt == STEP_LAST) begin
            cen   <= 1'b0;
            cnt   <= '0;
            state <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: clock opens only once the domain reset has been released
  p_clk_after_rst_r5: assert property (@(posedge clk) disable iff (srst)
    busy && $rose(cen) |-> !drst);

  // R5: isolation drops only on a clocked domain that is out of reset
  p_deiso_order_r5: assert property (@(posedge clk) disable iff (srst)
    $fell(iso) && $past(busy) |-> cen && !drst);

  // R7: sleep gates the clock only behind isolation
  p_sleep_order_r7: assert property (@(posedge clk) disable iff (srst)
    $fell(cen) && $past(busy) |-> iso);

  // R7: a running sequence never raises a released domain reset
  p_rst_quiet_r7: assert property (@(posedge clk) disable iff (srst)
    busy && !drst |=> !drst);

  // R8: busy and awake are exclusive
  p_exclusive_r8: assert property (@(posedge clk) disable iff (srst)
    !(busy && awake));

  // R6: a wake command to an awake idle domain starts nothing
  p_wake_blocked_r6: assert property (@(posedge clk) disable iff (srst)
    awake && !busy && wake_cmd && !sleep_cmd |=> !busy);
endmodule

// File: rtl/domain_seq_ctrl.sv
module domain_seq_ctrl
  import domseq_pkg::*;
#(
  parameter int N_DOM       = 8,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32,
  parameter int HOLD_CYC    = 4,
  parameter int STEP_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_DOM-1:0]  wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_DOM-1:0]  iso_o,
  output logic [N_DOM-1:0]  clk_en_o,
  output logic [N_DOM-1:0]  dom_rst_o,
  output logic [N_DOM-1:0]  busy_o,
  output logic [N_DOM-1:0]  awake_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic              srst;
  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              sel_iso, sel_cen, sel_rst, sel_wake, sel_sleep;

  domseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk      (clk),
    .rst_async(rst),
    .rst_sync (srst)
  );

  assign word      = addr[ADDR_W-1:2];
  assign aligned   = (addr[1:0] == 2'b00);
  assign sel_iso   = wr_en && aligned && (word == WORD_W'(REG_ISO));
  assign sel_cen   = wr_en && aligned && (word == WORD_W'(REG_CEN));
  assign sel_rst   = wr_en && aligned && (word == WORD_W'(REG_RST));
  assign sel_wake  = wr_en && aligned && (word == WORD_W'(REG_WAKE));
  assign sel_sleep = wr_en && aligned && (word == WORD_W'(REG_SLEEP));

  for (genvar g = 0; g < N_DOM; g++) begin : g_dom
    domseq_unit #(.HOLD_CYC(HOLD_CYC), .STEP_CYC(STEP_CYC)) u_unit (
      .clk      (clk),
      .srst     (srst),
      .wr_iso   (sel_iso),
      .wr_cen   (sel_cen),
      .wr_rst   (sel_rst),
      .d        (wdata[g]),
      .wake_cmd (sel_wake && wdata[g]),
      .sleep_cmd(sel_sleep && wdata[g]),
      .iso      (iso_o[g]),
      .cen      (clk_en_o[g]),
      .drst     (dom_rst_o[g]),
      .busy     (busy_o[g]),
      .awake    (awake_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (srst || !aligned) begin
      rdata <= '0;
    end else begin
      case (word)
        WORD_W'(REG_ISO):  rdata <= DATA_W'(iso_o);
        WORD_W'(REG_CEN):  rdata <= DATA_W'(clk_en_o);
        WORD_W'(REG_RST):  rdata <= DATA_W'(dom_rst_o);
        WORD_W'(REG_STAT): rdata <= DATA_W'({awake_o, busy_o});
        default:           rdata <= '0;
      endcase
    end
  end
endmodule

// File: tb/domain_seq_ctrl_bench.sv
module domain_seq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [4:0]  addr;
  logic [7:0]  wdata;
  logic [31:0] rdata;
  logic [7:0]  iso_o, clk_en_o, dom_rst_o, busy_o, awake_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  domain_seq_ctrl u_domain_seq_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .iso_o(iso_o), .clk_en_o(clk_en_o), .dom_rst_o(dom_rst_o),
    .busy_o(busy_o), .awake_o(awake_o)
  );

  // behavioural reference model
  logic [7:0]  m_iso = 8'hFF, m_cen = 8'h00, m_rst = 8'h00;
  int          m_mode [8];   // 0 idle, 1 waking, 2 sleeping
  int          m_t    [8];
  logic [31:0] m_rdata = '0;
  logic [31:0] rd_next;
  int          since_rel = 0;
  bit          started = 0;
  int          w;

  function automatic logic [7:0] m_busy();
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = (m_mode[i] != 0);
    return b;
  endfunction

  task automatic model_reset();
    m_iso = 8'hFF; m_cen = 8'h00; m_rst = 8'h00; m_rdata = '0;
    for (int i = 0; i < 8; i++) begin m_mode[i] = 0; m_t[i] = 0; end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst || since_rel < 2) begin
      model_reset();
    end else begin
      w = (addr[1:0] == 2'b00) ? int'(addr[4:2]) : 7;
      case (w)
        0: rd_next = {24'h0, m_iso};
        1: rd_next = {24'h0, m_cen};
        2: rd_next = {24'h0, m_rst};
        5: rd_next = {16'h0, m_cen & ~m_iso & ~m_rst, m_busy()};
        default: rd_next = '0;
      endcase
      for (int i = 0; i < 8; i++) begin
        if (m_mode[i] == 1) begin
          m_t[i]++;
          if (m_t[i] == 4) m_rst[i] = 1'b0;
          if (m_t[i] == 6) m_cen[i] = 1'b1;
          if (m_t[i] == 8) begin m_iso[i] = 1'b0; m_mode[i] = 0; end
        end else if (m_mode[i] == 2) begin
          m_t[i]++;
          if (m_t[i] == 2) begin m_cen[i] = 1'b0; m_mode[i] = 0; end
        end else if (wr_en) begin
          if (w == 3 && wdata[i] && !(m_cen[i] && !m_iso[i] && !m_rst[i])) begin
            m_mode[i] = 1; m_t[i] = 0; m_rst[i] = 1'b1; m_iso[i] = 1'b1; m_cen[i] = 1'b0;
          end else if (w == 4 && wdata[i]) begin
            m_mode[i] = 2; m_t[i] = 0; m_iso[i] = 1'b1;
          end else if (w == 0) m_iso[i] = wdata[i];
          else if (w == 1) m_cen[i] = wdata[i];
          else if (w == 2) m_rst[i] = wdata[i];
        end
      end
      m_rdata = rd_next;
    end
    if (rst) since_rel = 0;
    else if (since_rel < 10) since_rel++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R2 R4 R7 R8 R9)
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2 model iso", {24'h0, iso_o}, {24'h0, m_iso});
      chk("R4 model clk_en", {24'h0, clk_en_o}, {24'h0, m_cen});
      chk("R4 model dom_rst", {24'h0, dom_rst_o}, {24'h0, m_rst});
      chk("R7 model busy", {24'h0, busy_o}, {24'h0, m_busy()});
      chk("R8 model awake", {24'h0, awake_o}, {24'h0, m_cen & ~m_iso & ~m_rst});
      chk("R9 model rdata", rdata, m_rdata);
    end
  end

  task automatic wr(logic [4:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 iso after reset", {24'h0, iso_o}, 32'hFF);
    chk("R1 clk_en after reset", {24'h0, clk_en_o}, 32'h00);
    chk("R1 dom_rst after reset", {24'h0, dom_rst_o}, 32'h00);
    chk("R1 busy after reset", {24'h0, busy_o}, 32'h00);

    // R11: writes on the first two edges after release are dropped
    rst = 1'b0; wr_en = 1'b1; addr = 5'h00; wdata = 8'h00;
    repeat (2) @(negedge clk);
    wr_en = 1'b0;
    chk("R11 write during release ignored", {24'h0, iso_o}, 32'hFF);
    wr(5'h00, 8'hFE);
    chk("R11 write after release honoured", {24'h0, iso_o}, 32'hFE);
    wr(5'h00, 8'hFF);

    // R2: direct control writes and read-back
    wr(5'h04, 8'h0F);
    chk("R2 clk_en write", {24'h0, clk_en_o}, 32'h0F);
    rd(5'h04, v); chk("R2 clk_en read", v, 32'h0F);
    wr(5'h08, 8'h03);
    chk("R2 dom_rst write", {24'h0, dom_rst_o}, 32'h03);
    rd(5'h08, v); chk("R2 dom_rst read", v, 32'h03);
    wr(5'h08, 8'h00);
    wr(5'h04, 8'h00);

    // R4: wake of domain 0 with exact step timing
    wr(5'h0C, 8'h01);
    chk("R4 reset pulse starts", {24'h0, dom_rst_o}, 32'h01);
    chk("R4 busy at start", {24'h0, busy_o}, 32'h01);
    repeat (3) @(negedge clk);
    chk("R4 reset still held", {24'h0, dom_rst_o}, 32'h01);
    @(negedge clk);
    chk("R4 reset released", {24'h0, dom_rst_o}, 32'h00);
    chk("R5 clock still gated", {24'h0, clk_en_o}, 32'h00);
    repeat (2) @(negedge clk);
    chk("R4 clock enabled", {24'h0, clk_en_o}, 32'h01);
    chk("R5 still isolated", {24'h0, iso_o}, 32'hFF);
    repeat (2) @(negedge clk);
    chk("R4 de-isolated", {24'h0, iso_o}, 32'hFE);
    chk("R4 busy cleared", {24'h0, busy_o}, 32'h00);

    // R8: status word
    rd(5'h14, v); chk("R8 status", v, 32'h0000_0100);

    // R6: wake of awake domain ignored
    wr(5'h0C, 8'h01);
    chk("R6 awake wake ignored busy", {24'h0, busy_o}, 32'h00);
    chk("R6 awake wake ignored rst", {24'h0, dom_rst_o}, 32'h00);

    // R10 + R3 + R6: two domains at once, write and command while busy
    wr(5'h0C, 8'h06);
    chk("R10 both busy", {24'h0, busy_o}, 32'h06);
    wr(5'h00, 8'h00);
    chk("R3 busy domains keep isolation", {24'h0, iso_o}, 32'h06);
    wr(5'h0C, 8'h02);
    repeat (5) @(negedge clk);
    chk("R6 no restart while busy", {24'h0, busy_o}, 32'h06);
    @(negedge clk);
    chk("R10 both finish together", {24'h0, busy_o}, 32'h00);
    chk("R10 both awake", {24'h0, awake_o}, 32'h07);

    // R7: sleep of domain 0
    wr(5'h10, 8'h01);
    chk("R7 isolated first", {24'h0, iso_o}, 32'h01);
    chk("R7 clock still on", {24'h0, clk_en_o}, 32'h07);
    @(negedge clk);
    chk("R7 clock on one cycle later", {24'h0, clk_en_o}, 32'h07);
    @(negedge clk);
    chk("R7 clock gated", {24'h0, clk_en_o}, 32'h06);
    chk("R7 reset untouched", {24'h0, dom_rst_o}, 32'h00);
    chk("R7 busy cleared", {24'h0, busy_o}, 32'h00);

    // R9: decode of command, unmapped and misaligned addresses
    rd(5'h18, v); chk("R9 unmapped reads zero", v, 32'h0);
    rd(5'h0C, v); chk("R9 command reads zero", v, 32'h0);
    rd(5'h03, v); chk("R9 misaligned reads zero", v, 32'h0);
    wr(5'h01, 8'hFF);
    chk("R9 misaligned write ignored", {24'h0, iso_o}, 32'h01);
    rd(5'h00, v); chk("R9 iso read", v, 32'h01);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule